// File: doc/BRIEF.md
# Converter Result Output Port

This block sits between the successive-approximation core of a 16-bit converter and the data pins of the chip. Each time the core strobes a new result, the block captures the word. It then either drives the word onto the data bus as a parallel value or sends it out as a framed serial stream. Static mode inputs select the behaviour:

- the port style (parallel or serial);
- which byte goes on which half of the bus;
- the output coding (straight binary, or two's complement formed by flipping the top bit);
- the serial clock source (generated inside, or taken from an external pin);
- the divide ratio of the internal serial clock;
- the clock polarity;
- the polarity of the frame-sync output.

In serial mode the parallel data pins stop driving, so the pins can carry serial-port configuration. The serial word leaves MSB first. A sync output marks the 16 bit times of the frame, and busy stays high until the last bit has gone out. When the external clock is selected, that clock is resynchronised to the system clock before it moves the shifter.

Top module: `adc_result_port`

## Requirements
- R1: After reset, busy is low, the sync output is at its inactive level and the captured word is zero. With parallel mode, straight coding and no swap, `dataOut` reads 0.
- R2: With `straightBin` high, the coded word equals the captured word. With `straightBin` low, bit 15 is inverted and bits 14:0 are unchanged.
- R3: In parallel mode, with `byteSwap` low, `dataOut[7:0]` carries coded bits 7:0 and `dataOut[15:8]` carries coded bits 15:8. With `byteSwap` high, the two bytes trade places.
- R4: When `serialSel` is low, `dataOe` is all ones. When `serialSel` is high, `dataOe` is all zeros, which includes pins 1:0.
- R5: A one-cycle `resultValid` captures `resultWord`. The new value appears on `dataOut` in the cycle after the capturing edge.
- R6: In serial mode with the internal clock, `resultValid` starts a frame of 16 bits, sent MSB first. `sdOut` changes only on falling edges of the uninverted serial clock, so each bit is stable at the rising edge. Busy stays high for the whole frame.
- R7: With the internal clock and `readAfterConv` high, the serial clock runs at the system clock divided by 2, 4, 8 or 16 for `divCode` values 0, 1, 2 and 3. Busy therefore lasts 32, 64, 128 or 256 cycles.
- R8: With the internal clock and `readAfterConv` low, `divCode` is ignored. The ratio is 2 and busy lasts 32 cycles.
- R9: With `extClkSel` high, the bits shift on falling edges of `sclkIn` XOR `sclkInv`, taken after a two-flop synchroniser. The frame ends after 16 such edges, and `sclkOut` is held at 0.
- R10: With `sclkInv` high, the internal serial clock on `sclkOut` is inverted, including its idle level.
- R11: With `syncActLow` low, `syncOut` is high during a frame and low when idle. With `syncActLow` high, the levels are reversed.
- R12: A `resultValid` that arrives while a frame is in progress does not restart or alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resultValid | input | 1 | One-cycle strobe for a new conversion result |
| resultWord | input | 16 | Conversion result |
| serialSel | input | 1 | 0 selects parallel mode, 1 selects serial mode |
| byteSwap | input | 1 | Exchanges the two bytes in parallel mode |
| straightBin | input | 1 | 1 selects straight binary, 0 selects two's complement |
| extClkSel | input | 1 | 1 shifts on the external clock input |
| readAfterConv | input | 1 | Enables the divide field in internal-clock mode |
| divCode | input | 2 | Internal serial clock divide code |
| sclkInv | input | 1 | Inverts the serial clock |
| syncActLow | input | 1 | Makes the sync output active low |
| sclkIn | input | 1 | External serial clock |
| dataOut | output | 16 | Parallel data bus value |
| dataOe | output | 16 | Per-pin output enable for the data bus |
| sdOut | output | 1 | Serial data |
| sclkOut | output | 1 | Internally generated serial clock |
| syncOut | output | 1 | Frame sync |
| busy | output | 1 | High while a serial frame is in progress |

## Verification
The assertions assume that the mode inputs stay constant for the whole of a frame. They also assume that each level of the external clock lasts several system cycles, so the synchroniser never misses an edge. The stimulus changes modes only while busy is low. It holds each `sclkIn` level for six cycles, and it pulses `resultValid` for a single cycle, including the one pulse that deliberately falls inside a frame.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef struct packed {
    logic loadWord;
    logic startFrame;
    logic shiftBit;
  } portStrobe_t;
endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resultValid,
  input  logic             serialSel,
  input  logic             extClkSel,
  input  logic             readAfterConv,
  input  logic [DIV_W-1:0] divCode,
  input  logic             sclkInv,
  input  logic             syncActLow,
  input  logic             sclkIn,
  output portStrobe_t      strobe,
  output logic             busy,
  output logic             sclkOut,
  output logic             syncOut
);
  localparam int BIT_CNT_W = $clog2(WORD_W);
  localparam int HALF_W    = 2 ** DIV_W;

  logic                 frameOn;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [HALF_W-1:0]    divCnt;
  logic [HALF_W-1:0]    halfMax;
  logic                 sclkPh;
  logic [DIV_W-1:0]     effCode;
  logic                 syncA, syncB, syncPrev;
  logic                 extFall, intFall;

  // divide field only honoured in internal-clock read-after-convert mode
  assign effCode = readAfterConv ? divCode : '0;
  assign halfMax = (HALF_W'(1) << effCode) - HALF_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= sclkIn ^ sclkInv;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign extFall = syncPrev & ~syncB;
  assign intFall = sclkPh && (divCnt == halfMax);

  assign strobe.loadWord   = resultValid;
  assign strobe.startFrame = resultValid && serialSel && !frameOn;
  assign strobe.shiftBit   = frameOn && (extClkSel ? extFall : intFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sclkPh <= 1'b0;
    end else if (!frameOn || extClkSel) begin
      divCnt <= '0;
      sclkPh <= 1'b0;
    end else if (divCnt == halfMax) begin
      divCnt <= '0;
      sclkPh <= ~sclkPh;
    end else begin
      divCnt <= divCnt + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOn <= 1'b0;
      bitCnt  <= '0;
    end else if (strobe.startFrame) begin
      frameOn <= 1'b1;
      bitCnt  <= '0;
    end else if (strobe.shiftBit) begin
      if (bitCnt == BIT_CNT_W'(WORD_W - 1)) frameOn <= 1'b0;
      else bitCnt <= bitCnt + BIT_CNT_W'(1);
    end
  end

  assign busy    = frameOn;
  assign sclkOut = extClkSel ? 1'b0 : (sclkPh ^ sclkInv);
  assign syncOut = frameOn ^ syncActLow;

  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOn) |-> $past(bitCnt) == BIT_CNT_W'(WORD_W - 1)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (frameOn && resultValid && !strobe.shiftBit) |=> (frameOn && $stable(bitCnt))); // R12
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!frameOn && !extClkSel) |-> (sclkOut == sclkInv)); // R10
  AST_EXT_NO_INT_CLK: assert property (@(posedge clk) disable iff (!rstN)
    extClkSel |-> !sclkOut); // R9
endmodule

// File: rtl/adc_port_datapath.sv
module adc_port_datapath
  import adc_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [WORD_W-1:0] resultWord,
  input  logic              straightBin,
  input  logic              byteSwap,
  input  logic              serialSel,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] dataOe,
  output logic              sdOut
);
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] resultReg;
  logic [WORD_W-1:0] shReg;
  logic [WORD_W-1:0] codedReg;
  logic [WORD_W-1:0] codedIn;

  function automatic logic [WORD_W-1:0] applyCoding(input logic [WORD_W-1:0] w,
                                                    input logic straight);
    return {w[WORD_W-1] ^ ~straight, w[WORD_W-2:0]};
  endfunction

  assign codedReg = applyCoding(resultReg, straightBin);
  assign codedIn  = applyCoding(resultWord, straightBin);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultReg <= '0;
    else if (strobe.loadWord) resultReg <= resultWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strobe.startFrame) shReg <= codedIn;
    else if (strobe.shiftBit) shReg <= {shReg[WORD_W-2:0], 1'b0};
  end

  assign sdOut = shReg[WORD_W-1];

  for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
    assign dataOut[g]          = byteSwap ? codedReg[g + BYTE_W] : codedReg[g];
    assign dataOut[g + BYTE_W] = byteSwap ? codedReg[g] : codedReg[g + BYTE_W];
  end

  assign dataOe = serialSel ? '0 : '1;

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |=> resultReg == $past(resultWord)); // R5
  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftBit && !strobe.startFrame) |=> sdOut == $past(shReg[WORD_W-2])); // R6
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.shiftBit && !strobe.startFrame) |=> $stable(sdOut)); // R6
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [WORD_W-1:0] resultWord,
  input  logic              serialSel,
  input  logic              byteSwap,
  input  logic              straightBin,
  input  logic              extClkSel,
  input  logic              readAfterConv,
  input  logic [DIV_W-1:0]  divCode,
  input  logic              sclkInv,
  input  logic              syncActLow,
  input  logic              sclkIn,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] dataOe,
  output logic              sdOut,
  output logic              sclkOut,
  output logic              syncOut,
  output logic              busy
);
  portStrobe_t strobe;

  adc_port_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .serialSel(serialSel),
    .extClkSel(extClkSel), .readAfterConv(readAfterConv), .divCode(divCode),
    .sclkInv(sclkInv), .syncActLow(syncActLow), .sclkIn(sclkIn),
    .strobe(strobe), .busy(busy), .sclkOut(sclkOut), .syncOut(syncOut)
  );

  adc_port_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resultWord(resultWord),
    .straightBin(straightBin), .byteSwap(byteSwap), .serialSel(serialSel),
    .dataOut(dataOut), .dataOe(dataOe), .sdOut(sdOut)
  );

  AST_SERIAL_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    serialSel |-> (dataOe[1:0] == 2'b00)); // R4
  AST_SYNC_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (syncOut == !syncActLow)); // R11
endmodule

// File: tb/adc_result_port_tb_top.sv
module adc_result_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [15:0] resultWord = '0;
  logic        serialSel = 1'b0, byteSwap = 1'b0, straightBin = 1'b1;
  logic        extClkSel = 1'b0, readAfterConv = 1'b0;
  logic [1:0]  divCode = '0;
  logic        sclkInv = 1'b0, syncActLow = 1'b0, sclkIn = 1'b0;
  logic [15:0] dataOut, dataOe;
  logic        sdOut, sclkOut, syncOut, busy;

  int nVec = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  adc_result_port dut_i (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultWord(resultWord),
    .serialSel(serialSel), .byteSwap(byteSwap), .straightBin(straightBin),
    .extClkSel(extClkSel), .readAfterConv(readAfterConv), .divCode(divCode),
    .sclkInv(sclkInv), .syncActLow(syncActLow), .sclkIn(sclkIn),
    .dataOut(dataOut), .dataOe(dataOe), .sdOut(sdOut), .sclkOut(sclkOut),
    .syncOut(syncOut), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseWord(input logic [15:0] w);
    resultWord  = w;
    resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic checkReset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(syncOut == 1'b0, "R1 sync", syncOut, 0);
    chk(dataOut == 16'h0, "R1 data", dataOut, 0);
    chk(dataOe == 16'hFFFF, "R4 parallel oe", dataOe, 16'hFFFF);
  endtask

  task automatic parTest(input logic [15:0] w, input bit swap, input bit straight);
    logic [15:0] coded, exp;
    serialSel = 1'b0; byteSwap = swap; straightBin = straight; extClkSel = 1'b0;
    @(negedge clk);
    pulseWord(w);
    coded = straight ? w : {~w[15], w[14:0]};
    exp   = swap ? {coded[7:0], coded[15:8]} : coded;
    chk(dataOut == exp, swap ? "R3 swapped" : (straight ? "R5 capture" : "R2 coding"),
        dataOut, exp);
    chk(dataOe == 16'hFFFF, "R4 parallel oe", dataOe, 16'hFFFF);
  endtask

  task automatic intFrame(input logic [15:0] w, input logic [1:0] code, input bit rac,
                          input bit inv, input bit sLow, input bit straight,
                          input bit midPulse);
    logic [15:0] exp, got;
    int half, cyc, nBits, syncBad;
    bit prevClk, eff;
    @(negedge clk);
    serialSel = 1'b1; extClkSel = 1'b0; divCode = code; readAfterConv = rac;
    sclkInv = inv; syncActLow = sLow; straightBin = straight;
    @(negedge clk);
    chk(sclkOut == inv, "R10 idle clock level", sclkOut, inv);
    chk(syncOut == sLow, "R11 idle sync level", syncOut, sLow);
    chk(dataOe == 16'h0, "R4 serial oe", dataOe, 0);
    pulseWord(w);
    exp  = straight ? w : {~w[15], w[14:0]};
    half = rac ? (1 << code) : 1;
    cyc = 0; nBits = 0; got = '0; prevClk = 1'b0; syncBad = 0;
    while (busy && cyc < 2000) begin
      eff = sclkOut ^ inv;
      if (eff && !prevClk) begin
        got = {got[14:0], sdOut};
        nBits++;
      end
      prevClk = eff;
      if (syncOut != !sLow) syncBad++;
      cyc++;
      if (midPulse && cyc == 5) begin
        resultWord  = ~w;
        resultValid = 1'b1;
      end else begin
        resultValid = 1'b0;
      end
      @(negedge clk);
    end
    resultValid = 1'b0;
    chk(cyc == 32 * half, rac ? "R7 frame length" : "R8 divide ignored", cyc, 32 * half);
    chk(got == exp, midPulse ? "R12 frame data kept" : "R6 serial data", got, exp);
    chk(nBits == 16, "R6 bit count", nBits, 16);
    chk(syncBad == 0, "R11 active sync", syncBad, 0);
    chk(syncOut == sLow, "R11 sync after frame", syncOut, sLow);
  endtask

  task automatic extFrame(input logic [15:0] w, input bit inv, input bit sLow);
    logic [15:0] got;
    int busyLow;
    @(negedge clk);
    serialSel = 1'b1; extClkSel = 1'b1; sclkInv = inv; syncActLow = sLow;
    straightBin = 1'b1; sclkIn = inv;
    repeat (5) @(negedge clk);
    chk(sclkOut == 1'b0, "R9 sclkOut held", sclkOut, 0);
    pulseWord(w);
    got = '0; busyLow = 0;
    for (int i = 0; i < 16; i++) begin
      got = {got[14:0], sdOut};
      if (!busy || syncOut != !sLow) busyLow++;
      sclkIn = ~inv;
      repeat (6) @(negedge clk);
      sclkIn = inv;
      repeat (6) @(negedge clk);
    end
    chk(got == w, "R9 external data", got, w);
    chk(busyLow == 0, "R9 busy during frame", busyLow, 0);
    chk(busy == 1'b0, "R9 frame end", busy, 0);
    chk(syncOut == sLow, "R11 ext sync idle", syncOut, sLow);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
    parTest(16'h1234, 1'b0, 1'b1);
    parTest(16'h1234, 1'b1, 1'b1);
    parTest(16'h8001, 1'b0, 1'b0);
    parTest(16'h7F80, 1'b1, 1'b0);
    intFrame(16'hA5C3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    intFrame(16'h3C96, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    intFrame(16'hF00D, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    intFrame(16'h5A5A, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    intFrame(16'h8421, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    extFrame(16'hC0DE, 1'b0, 1'b0);
    extFrame(16'h1E2D, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule